// File: doc/BRIEF.md
# PCIe Compliance Pattern Generator

This block produces the repeating test pattern that a PCI Express transmitter sends while its link is in the polling compliance substate. The pattern is a four-symbol cycle of two commas and two data characters. The block also encodes each symbol into a 10-bit code group, so a serializer can take its output directly. It supports only the three code groups that the pattern needs, and it carries the running disparity from one symbol to the next.

The lane is 8 or 16 bits wide, set by a parameter. Each byte lane has a force strobe. The strobe is raised only on the comma that opens the pattern after enable rises, and it forces that comma to encode from negative running disparity. In the 16-bit configuration the low byte is sent first, and the disparity that results from it is passed to the high byte within the same cycle.

Top module: `pcie_cmpl_gen`

## Requirements
- R1: While reset is held low, `vld_o`, `sym_o`, `ctl_o`, `frc_o` and `code_o` are all zero. The tracked running disparity resets to negative.
- R2: While `en` is high, the byte stream cycles through 0xBC (K28.5), 0xB5 (D21.5), 0xBC (K28.5), 0x4A (D10.2), in that order, with no gaps. Every enable starts at the first 0xBC.
- R3: With a 16-bit lane, byte 0 (`sym_o[7:0]`) holds the earlier symbol of each pair and byte 1 holds the later one. Every valid cycle therefore carries 0xBC in byte 0, with 0xB5 and 0x4A alternating in byte 1.
- R4: `ctl_o[b]` is high exactly when byte b is the comma 0xBC, and low for 0xB5 and 0x4A.
- R5: `frc_o[0]` is high only in the first valid cycle after `en` rises, and that cycle carries 0xBC in byte 0. The other bits of `frc_o`, and every later cycle, stay low.
- R6: `code_o[10*b+9 : 10*b]` holds the code group of byte b, written with its leftmost character at the top bit. The comma encodes as 0011111010 from negative disparity and as 1100000101 from positive disparity. 0xB5 encodes as 1010101010 and 0x4A as 0101010101, whatever the disparity.
- R7: Each comma flips the running disparity. The two data characters leave it unchanged. The disparity carries over from cycle to cycle.
- R8: A byte whose force bit is high encodes from negative disparity, even when the tracked disparity is positive.
- R9: With a 16-bit lane, the disparity that byte 0 leaves behind is the disparity byte 1 encodes from, in the same cycle.
- R10: When `en` is low, the outputs are idle (all zero) and the pattern rewinds to its start. The tracked disparity is kept.
- R11: `vld_o` and the output fields follow `en` with one register stage: `en` sampled at a rising edge is reflected on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the compliance pattern |
| vld_o | output | 1 | Output fields carry pattern data |
| sym_o | output | LANE_W | Unencoded pattern bytes, byte 0 first |
| ctl_o | output | LANE_W/8 | Control-character flag per byte |
| frc_o | output | LANE_W/8 | Force-negative-disparity strobe per byte |
| code_o | output | 10*LANE_W/8 | Encoded 10-bit code groups per byte |

## Verification
One bench drives an 8-bit and a 16-bit instance with the same enable stream. A long continuous run checks the symbol order, the byte packing and the steady alternation of comma encodings. A one-cycle enable pulse leaves the tracked disparity positive. The restart that follows can then show the force override, because without the override the opening comma would take its positive-disparity code. A disable in the middle of the pattern, followed by re-enable, shows that the pattern rewinds to the first comma and that the force strobe fires only once per enable.

// File: rtl/cpat_pkg.sv
package cpat_pkg;

   localparam logic [7:0] SYM_COMMA = 8'hBC;
   localparam logic [7:0] SYM_D215  = 8'hB5;
   localparam logic [7:0] SYM_D102  = 8'h4A;

   localparam logic [9:0] CG_COMMA_NEG = 10'b0011111010;
   localparam logic [9:0] CG_COMMA_POS = 10'b1100000101;
   localparam logic [9:0] CG_D215      = 10'b1010101010;
   localparam logic [9:0] CG_D102      = 10'b0101010101;

   localparam int PAT_LEN = 4;
   localparam int PAT_IW  = $clog2(PAT_LEN);

   function automatic logic [7:0] pat_sym(input logic [PAT_IW-1:0] idx);
      case (idx)
         2'd0:    pat_sym = SYM_COMMA;
         2'd1:    pat_sym = SYM_D215;
         2'd2:    pat_sym = SYM_COMMA;
         default: pat_sym = SYM_D102;
      endcase
   endfunction

   function automatic logic pat_is_ctl(input logic [PAT_IW-1:0] idx);
      pat_is_ctl = ~idx[0];
   endfunction

endpackage

// File: rtl/cpat_seq.sv
module cpat_seq #(
   parameter int NB = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   output logic            vld_o,
   output logic [8*NB-1:0] sym_o,
   output logic [NB-1:0]   ctl_o,
   output logic [NB-1:0]   frc_o
);
   import cpat_pkg::*;

   localparam logic [PAT_IW-1:0] STEP = PAT_IW'(NB);

   logic [PAT_IW-1:0] idx_q;
   logic              arm_q;
   logic [8*NB-1:0]   sym_d;
   logic [NB-1:0]     ctl_d;

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         sym_d[8*b +: 8] = pat_sym(idx_q + PAT_IW'(b));
         ctl_d[b]        = pat_is_ctl(idx_q + PAT_IW'(b));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         arm_q <= 1'b1;
         vld_o <= 1'b0;
         sym_o <= '0;
         ctl_o <= '0;
         frc_o <= '0;
      end else if (en) begin
         idx_q    <= idx_q + STEP;
         arm_q    <= 1'b0;
         vld_o    <= 1'b1;
         sym_o    <= sym_d;
         ctl_o    <= ctl_d;
         frc_o    <= '0;
         frc_o[0] <= arm_q;
      end else begin
         idx_q <= '0;
         arm_q <= 1'b1;
         vld_o <= 1'b0;
         sym_o <= '0;
         ctl_o <= '0;
         frc_o <= '0;
      end
   end

   AST_FRC_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
      frc_o[0] |-> (ctl_o[0] && sym_o[7:0] == SYM_COMMA)); // R5

   AST_FRC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && $past(vld_o)) |-> (frc_o == '0)); // R5

   AST_RESTART_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_o) |-> frc_o[0]); // R10

   AST_VLD_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> vld_o); // R11

endmodule

// File: rtl/cpat_enc_lane.sv
module cpat_enc_lane (
   input  logic [7:0] sym_i,
   input  logic       ctl_i,
   input  logic       rd_i,
   output logic [9:0] code_o,
   output logic       rd_o
);
   import cpat_pkg::*;

   always_comb begin
      code_o = '0;
      rd_o   = rd_i;
      if (ctl_i) begin
         code_o = rd_i ? CG_COMMA_POS : CG_COMMA_NEG;
         rd_o   = ~rd_i;
      end else begin
         case (sym_i)
            SYM_D215: code_o = CG_D215;
            SYM_D102: code_o = CG_D102;
            default:  code_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/pcie_cmpl_gen.sv
module pcie_cmpl_gen #(
   parameter int LANE_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   output logic                    vld_o,
   output logic [LANE_W-1:0]       sym_o,
   output logic [LANE_W/8-1:0]     ctl_o,
   output logic [LANE_W/8-1:0]     frc_o,
   output logic [10*LANE_W/8-1:0]  code_o
);
   localparam int NB = LANE_W / 8;

   if (!(LANE_W == 8 || LANE_W == 16)) begin : g_bad_width
      $error("pcie_cmpl_gen: LANE_W must be 8 or 16");
   end

   logic          rd_q;
   logic [NB:0]   rd_c;
   logic [NB-1:0] rd_in;

   cpat_seq #(.NB(NB)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .vld_o (vld_o),
      .sym_o (sym_o),
      .ctl_o (ctl_o),
      .frc_o (frc_o)
   );

   assign rd_c[0] = rd_q;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [9:0] lane_code;

      assign rd_in[b] = frc_o[b] ? 1'b0 : rd_c[b];

      cpat_enc_lane u_enc (
         .sym_i  (sym_o[8*b +: 8]),
         .ctl_i  (ctl_o[b]),
         .rd_i   (rd_in[b]),
         .code_o (lane_code),
         .rd_o   (rd_c[b+1])
      );

      assign code_o[10*b +: 10] = vld_o ? lane_code : 10'd0;

      AST_WEIGHT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_o && !rd_in[b]) |-> ($countones(code_o[10*b +: 10]) >= 5)); // R7

      AST_WEIGHT_POS: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_o && rd_in[b]) |-> ($countones(code_o[10*b +: 10]) <= 5)); // R7

      AST_FORCED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
         frc_o[b] |-> (code_o[10*b +: 10] == cpat_pkg::CG_COMMA_NEG)); // R8
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= 1'b0;
      else if (vld_o) rd_q <= rd_c[NB];
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> (code_o == '0 && frc_o == '0 && sym_o == '0)); // R10

   if (NB == 2) begin : g_ctl_wide
      AST_CTL_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
         vld_o |-> (ctl_o == 2'b01)); // R4
   end else begin : g_ctl_narrow
      AST_CTL_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_o && $past(vld_o)) |-> (ctl_o != $past(ctl_o))); // R4
   end

endmodule

// File: tb/tb_pcie_cmpl_gen.sv
`timescale 1ns/1ps
module tb_pcie_cmpl_gen;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, en;

   logic        w_vld;
   logic [15:0] w_sym;
   logic [1:0]  w_ctl, w_frc;
   logic [19:0] w_code;
   logic        n_vld;
   logic [7:0]  n_sym;
   logic [0:0]  n_ctl, n_frc;
   logic [9:0]  n_code;

   pcie_cmpl_gen #(.LANE_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .vld_o(w_vld), .sym_o(w_sym),
      .ctl_o(w_ctl), .frc_o(w_frc), .code_o(w_code));

   pcie_cmpl_gen #(.LANE_W(8)) dut_n (
      .clk(clk), .rst_n(rst_n), .en(en), .vld_o(n_vld), .sym_o(n_sym),
      .ctl_o(n_ctl), .frc_o(n_frc), .code_o(n_code));

   typedef struct packed {
      logic        vld;
      logic [15:0] sym;
      logic [1:0]  ctl;
      logic [1:0]  frc;
      logic [19:0] code;
   } exp_t;

   exp_t  qw[$];
   exp_t  qn[$];
   string tq[$];
   int    checks = 0;
   int    fails  = 0;
   string phase  = "R1";

   int   iw, in8;
   logic rdw, rdn, armw, armn;

   function automatic logic [7:0] ref_sym(input int i);
      case (i % 4)
         0:       return 8'hBC;
         1:       return 8'hB5;
         2:       return 8'hBC;
         default: return 8'h4A;
      endcase
   endfunction

   function automatic logic [9:0] ref_code(input logic [7:0] s, input logic rd);
      if (s == 8'hBC) return rd ? 10'b1100000101 : 10'b0011111010;
      if (s == 8'hB5) return 10'b1010101010;
      return 10'b0101010101;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // Reference model: one enable sample per call, expected output pushed
   task automatic step(input logic e);
      exp_t ew, en_;
      logic [7:0] s0, s1;
      logic r0, r1;
      @(negedge clk);
      en = e;
      ew = '0; en_ = '0;
      if (e) begin
         // 16-bit lane, byte 0 first, disparity chained into byte 1 (R3, R9)
         s0 = ref_sym(iw); s1 = ref_sym(iw + 1);
         r0 = armw ? 1'b0 : rdw;
         r1 = (s0 == 8'hBC) ? ~r0 : r0;
         ew.vld = 1'b1;
         ew.sym = {s1, s0};
         ew.ctl = {s1 == 8'hBC, s0 == 8'hBC};
         ew.frc = {1'b0, armw};
         ew.code = {ref_code(s1, r1), ref_code(s0, r0)};
         rdw = (s1 == 8'hBC) ? ~r1 : r1;
         iw = (iw + 2) % 4; armw = 1'b0;
         // 8-bit lane
         s0 = ref_sym(in8);
         r0 = armn ? 1'b0 : rdn;
         en_.vld = 1'b1;
         en_.sym = {8'h00, s0};
         en_.ctl = {1'b0, s0 == 8'hBC};
         en_.frc = {1'b0, armn};
         en_.code = {10'd0, ref_code(s0, r0)};
         rdn = (s0 == 8'hBC) ? ~r0 : r0;
         in8 = (in8 + 1) % 4; armn = 1'b0;
      end else begin
         iw = 0; in8 = 0; armw = 1'b1; armn = 1'b1;
      end
      qw.push_back(ew); qn.push_back(en_); tq.push_back(phase);
   endtask

   // Monitor: compare shortly after each rising edge
   always @(posedge clk) begin
      exp_t  ew, en_;
      string t;
      #1;
      if (qw.size() > 0) begin
         ew = qw.pop_front(); en_ = qn.pop_front(); t = tq.pop_front();
         chk(t, "R11 vld16",  32'(w_vld),  32'(ew.vld));
         chk(t, "R2 sym16",   32'(w_sym),  32'(ew.sym));
         chk(t, "R4 ctl16",   32'(w_ctl),  32'(ew.ctl));
         chk(t, "R5 frc16",   32'(w_frc),  32'(ew.frc));
         chk(t, "R6 code16",  32'(w_code), 32'(ew.code));
         chk(t, "R11 vld8",   32'(n_vld),  32'(en_.vld));
         chk(t, "R2 sym8",    32'(n_sym),  32'(en_.sym[7:0]));
         chk(t, "R4 ctl8",    32'(n_ctl),  32'(en_.ctl[0]));
         chk(t, "R5 frc8",    32'(n_frc),  32'(en_.frc[0]));
         chk(t, "R6 code8",   32'(n_code), 32'(en_.code[9:0]));
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog expired act=running exp=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b0;
      iw = 0; in8 = 0; rdw = 1'b0; rdn = 1'b0; armw = 1'b1; armn = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs under reset
      chk("R1", "vld16", 32'(w_vld), 32'd0);
      chk("R1", "code16", 32'(w_code), 32'd0);
      chk("R1", "frc16", 32'(w_frc), 32'd0);
      chk("R1", "sym8", 32'(n_sym), 32'd0);
      chk("R1", "code8", 32'(n_code), 32'd0);
      rst_n = 1'b1;
      step(1'b0);
      // R2 R3 R7 R9: continuous run from reset disparity
      phase = "R7";
      for (int k = 0; k < 12; k++) step(1'b1);
      // R10: disable mid-pattern, then rewind
      phase = "R10";
      step(1'b0); step(1'b0);
      for (int k = 0; k < 3; k++) step(1'b1);
      step(1'b0);
      // one-cycle pulse leaves tracked disparity positive in both widths
      phase = "R9";
      step(1'b1);
      step(1'b0); step(1'b0);
      // R8: forced comma must still encode from negative disparity
      phase = "R8";
      for (int k = 0; k < 6; k++) step(1'b1);
      step(1'b0);
      phase = "R3";
      for (int k = 0; k < 9; k++) step(1'b1);
      step(1'b0);
      repeat (3) @(posedge clk);
      #1;
      summary();
      $finish;
   end

endmodule